// File: doc/BRIEF.md
# Fault hiccup and lockout controller

This block supervises the protection behaviour of a quasi-resonant flyback switching controller. It takes digital flags from analog comparators that sit outside it: the feedback loop being out of regulation, an over-voltage trip, and the supply rail being above the start-up threshold or below the stop threshold. It produces two controls: one that gates the power switch drive, and one that makes the oscillator fall back to free-running borderline switching.

A loop fault must persist for a full qualification window before drive is cut. Drive then stays off for eight windows. If the fault is still present at the end of that time, drive comes back for one more window and the cycle repeats, giving burst-mode hiccup operation. If the loop recovers during the off period, the block waits and restarts only on the next rise of the supply above the start-up threshold. An over-voltage trip latches drive off until the supply drops below the stop threshold. The window is built from a clock prescaler (`TICK_DIV` clocks per tick) and a tick count (`QUAL_TICKS`), so W = `TICK_DIV` × `QUAL_TICKS` clock cycles.

Top module: `fault_hiccup_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block enters the supply-wait state, and `drive_en` and `vco_bypass` are 0.
- R2: In the supply-wait state, drive starts one cycle after `vcc_above_start` changes from 0 to 1. A level that stays at 1 without a 0-to-1 change does not start drive. A 1 sampled at the first edge after reset counts as a change.
- R3: While drive is enabled, `vcc_below_stop` = 1 turns `drive_en` off one cycle later and returns the block to the supply-wait state.
- R4: The internal loop-fault flag sets one cycle after `fb_low` = 1. It clears one cycle after `fb_low` = 0 together with `fb_recovered` = 1. With both inputs at 0, it holds its value. `vco_bypass` equals this flag.
- R5: A loop-fault flag that clears before the qualification window of W cycles expires leaves `drive_en` at 1 throughout.
- R6: With drive running, a persistent `fb_low` turns `drive_en` off exactly W+2 cycles after it is first applied.
- R7: The off period lasts exactly 8·W cycles. If the flag is still set at its end, drive returns for W cycles and then turns off again, repeating the burst.
- R8: If the flag clears during the off period, drive stays off with `vcc_above_start` held high. It restarts one cycle after the next 0-to-1 change of `vcc_above_start`.
- R9: `ovp_trip` = 1 while drive is enabled turns `drive_en` off one cycle later and latches it off. Release of `ovp_trip` or a rise of the supply does not restart drive. Only `vcc_below_stop` = 1 leaves the latch, after which R2 applies.
- R10: During the off period, `vcc_below_stop` and `vcc_above_start` activity is ignored: the off period still ends exactly 8·W cycles after it began.
- R11: In the supply-wait state, `ovp_trip` = 1 while `vcc_below_stop` = 0 enters the latch, so a later supply rise does not start drive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fb_low | input | 1 | Loop out of regulation (virtual ground below limit) |
| fb_recovered | input | 1 | Feedback back inside regulation by the hysteresis margin |
| ovp_trip | input | 1 | Over-voltage comparator output |
| vcc_above_start | input | 1 | Supply above the start-up threshold |
| vcc_below_stop | input | 1 | Supply below the stop threshold |
| drive_en | output | 1 | Enables the power switch drive |
| vco_bypass | output | 1 | Forces free-running borderline switching |

## Verification
Some results appear one cycle after their stimulus, because they pass through a single state register: supply start, undervoltage stop and over-voltage latching. Loop-fault effects pass through two registers, the fault flag and then the state, so the flag shows on `vco_bypass` after one cycle. The drive cut-off falls exactly W+2 cycles after `fb_low` rises, and each off period lasts exactly 8·W cycles. The bench keeps a running cycle count from the fault onset and samples on falling edges at the last cycle before each predicted edge and at the edge itself. A transition that is off by one cycle is therefore caught in either direction. The short-fault sweep checks drive on every cycle over the whole window for a range of fault lengths.

// File: rtl/fsup_pkg.sv
// Shared types for the fault hiccup and lockout controller.
// Assumes: one state register in the top module uses this encoding.
package fsup_pkg;
    typedef enum logic [2:0] {
        ST_WAIT_SUPPLY = 3'd0,
        ST_RUN         = 3'd1,
        ST_QUALIFY     = 3'd2,
        ST_HICCUP_OFF  = 3'd3,
        ST_OVP_LATCH   = 3'd4
    } fsup_state_e;
endpackage

// File: rtl/fsup_tick.sv
// Tick prescaler: pulses tick once every TICK_DIV clocks.
// Assumes: restart re-aligns the phase so that the first tick after a
// restart arrives on the TICK_DIV-th cycle.
module fsup_tick #(
    parameter int TICK_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic tick
);
    localparam int CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

    logic [CW-1:0] div_cnt;

    // Decode the terminal count of the divider.
    assign tick = (div_cnt == CW'(TICK_DIV - 1));

    // Advance the divider, wrapping at the terminal count.
    always_ff @(posedge clk) begin
        if (!rst_n || restart || tick) div_cnt <= '0;
        else                           div_cnt <= div_cnt + 1'b1;
    end
endmodule

// File: rtl/fsup_window.sv
// Window timer: counts ticks since the last restart and flags the end of
// the qualification window and of the long off period.
// Assumes: the count saturates, so it never wraps in states that do not
// use it.
module fsup_window #(
    parameter int QUAL_TICKS = 8,
    parameter int OFF_MULT   = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic tick,
    output logic qual_done,
    output logic off_done
);
    localparam int OFF_TICKS = QUAL_TICKS * OFF_MULT;
    localparam int CW        = $clog2(OFF_TICKS + 1);

    logic [CW-1:0] tick_cnt;
    logic          at_last;

    assign at_last   = (tick_cnt == CW'(OFF_TICKS - 1));
    assign qual_done = tick && (tick_cnt == CW'(QUAL_TICKS - 1));
    assign off_done  = tick && at_last;

    // Count ticks, holding at the last value of the off period.
    always_ff @(posedge clk) begin
        if (!rst_n || restart)  tick_cnt <= '0;
        else if (tick && !at_last) tick_cnt <= tick_cnt + 1'b1;
    end
endmodule

// File: rtl/fsup_loop_flag.sv
// Loop-fault flag with hysteresis: set by the low-feedback comparator and
// cleared only by the recovered comparator.
// Assumes: the two comparators have separate thresholds; set wins if both
// are high.
module fsup_loop_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic fb_low,
    input  logic fb_recovered,
    output logic fault
);
    // Set on a low loop, clear on recovery, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n)            fault <= 1'b0;
        else if (fb_low)       fault <= 1'b1;
        else if (fb_recovered) fault <= 1'b0;
    end
endmodule

// File: rtl/fault_hiccup_ctrl.sv
// Fault hiccup and lockout controller (top).
// Qualifies loop faults over a window of TICK_DIV*QUAL_TICKS clocks, then
// enforces an off period of OFF_MULT windows. Latches over-voltage until
// the supply falls below the stop threshold. Restarts only on a rising
// supply-start crossing.
// Assumes: all inputs are synchronous to clk.
module fault_hiccup_ctrl
    import fsup_pkg::*;
#(
    parameter int TICK_DIV   = 4,
    parameter int QUAL_TICKS = 8,
    parameter int OFF_MULT   = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fb_low,
    input  logic fb_recovered,
    input  logic ovp_trip,
    input  logic vcc_above_start,
    input  logic vcc_below_stop,
    output logic drive_en,
    output logic vco_bypass
);
    fsup_state_e state, state_nxt;
    logic        loop_fault;
    logic        start_q;
    logic        start_rise;
    logic        restart;
    logic        tick;
    logic        qual_done;
    logic        off_done;

    fsup_loop_flag u_flag (
        .clk          (clk),
        .rst_n        (rst_n),
        .fb_low       (fb_low),
        .fb_recovered (fb_recovered),
        .fault        (loop_fault)
    );

    fsup_tick #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .tick    (tick)
    );

    fsup_window #(.QUAL_TICKS(QUAL_TICKS), .OFF_MULT(OFF_MULT)) u_win (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart   (restart),
        .tick      (tick),
        .qual_done (qual_done),
        .off_done  (off_done)
    );

    // Remember the previous start-threshold level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) start_q <= 1'b0;
        else        start_q <= vcc_above_start;
    end

    assign start_rise = vcc_above_start && !start_q;

    // Choose the next protection state.
    always_comb begin
        state_nxt = state;
        case (state)
            ST_WAIT_SUPPLY: begin
                if (ovp_trip && !vcc_below_stop) state_nxt = ST_OVP_LATCH;
                else if (start_rise)             state_nxt = ST_RUN;
            end
            ST_RUN: begin
                if (vcc_below_stop)  state_nxt = ST_WAIT_SUPPLY;
                else if (ovp_trip)   state_nxt = ST_OVP_LATCH;
                else if (loop_fault) state_nxt = ST_QUALIFY;
            end
            ST_QUALIFY: begin
                if (vcc_below_stop)   state_nxt = ST_WAIT_SUPPLY;
                else if (ovp_trip)    state_nxt = ST_OVP_LATCH;
                else if (!loop_fault) state_nxt = ST_RUN;
                else if (qual_done)   state_nxt = ST_HICCUP_OFF;
            end
            ST_HICCUP_OFF: begin
                if (ovp_trip)         state_nxt = ST_OVP_LATCH;
                else if (!loop_fault) state_nxt = ST_WAIT_SUPPLY;
                else if (off_done)    state_nxt = ST_QUALIFY;
            end
            ST_OVP_LATCH: begin
                if (vcc_below_stop) state_nxt = ST_WAIT_SUPPLY;
            end
            default: state_nxt = ST_WAIT_SUPPLY;
        endcase
    end

    // Restart both timers on every state change.
    assign restart = (state_nxt != state);

    // Hold the protection state.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_WAIT_SUPPLY;
        else        state <= state_nxt;
    end

    assign drive_en   = (state == ST_RUN) || (state == ST_QUALIFY);
    assign vco_bypass = loop_fault;
endmodule

// File: rtl/fault_hiccup_ctrl_chk.sv
// Property checker for the fault hiccup and lockout controller, bound to
// every instance of the top module.
module fault_hiccup_ctrl_chk
    import fsup_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        fb_low,
    input logic        fb_recovered,
    input logic        ovp_trip,
    input logic        vcc_above_start,
    input logic        vcc_below_stop,
    input logic        drive_en,
    input logic        vco_bypass,
    input fsup_state_e state
);
    AST_NO_START_WITHOUT_SUPPLY: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT_SUPPLY && !vcc_above_start) |=> !drive_en); // R2

    AST_UVLO_STOPS_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (drive_en && vcc_below_stop) |=> !drive_en); // R3

    AST_FLAG_HOLDS_IN_BAND: assert property (@(posedge clk) disable iff (!rst_n)
        (!fb_low && !fb_recovered) |=> $stable(vco_bypass)); // R4

    AST_FLAG_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        fb_low |=> vco_bypass); // R4

    AST_OVP_CUTS_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (drive_en && ovp_trip) |=> !drive_en); // R9

    AST_OVP_LATCH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OVP_LATCH && !vcc_below_stop) |=> (state == ST_OVP_LATCH)); // R9
endmodule

bind fault_hiccup_ctrl fault_hiccup_ctrl_chk u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .fb_low          (fb_low),
    .fb_recovered    (fb_recovered),
    .ovp_trip        (ovp_trip),
    .vcc_above_start (vcc_above_start),
    .vcc_below_stop  (vcc_below_stop),
    .drive_en        (drive_en),
    .vco_bypass      (vco_bypass),
    .state           (state)
);

// File: tb/fault_hiccup_ctrl_test.sv
`timescale 1ns/1ps
module fault_hiccup_ctrl_test;
    localparam int TICK_DIV   = 4;
    localparam int QUAL_TICKS = 8;
    localparam int OFF_MULT   = 8;
    localparam int W          = TICK_DIV * QUAL_TICKS;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic fb_low = 1'b0, fb_recovered = 1'b0, ovp_trip = 1'b0;
    logic vcc_above_start = 1'b0, vcc_below_stop = 1'b1;
    logic drive_en, vco_bypass;

    int checks = 0;
    int errors = 0;
    int t = 0;

    always #5 clk = ~clk;

    fault_hiccup_ctrl #(.TICK_DIV(TICK_DIV), .QUAL_TICKS(QUAL_TICKS), .OFF_MULT(OFF_MULT)) uut (
        .clk(clk), .rst_n(rst_n), .fb_low(fb_low), .fb_recovered(fb_recovered),
        .ovp_trip(ovp_trip), .vcc_above_start(vcc_above_start),
        .vcc_below_stop(vcc_below_stop), .drive_en(drive_en), .vco_bypass(vco_bypass)
    );

    // Step n rising edges and land on the following falling edge.
    task automatic adv(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            t++;
        end
        @(negedge clk);
    endtask

    task automatic adv_to(input int target);
        adv(target - t);
    endtask

    task automatic chk(input logic act, input logic exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b (t=%0d)", what, act, exp, t);
        end
    endtask

    // Clean supply restart: drop the start level, then raise it.
    task automatic supply_restart();
        vcc_below_stop = 1'b0;
        vcc_above_start = 1'b0;
        adv(1);
        vcc_above_start = 1'b1;
        adv(1);
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int t0;
        @(negedge clk);
        adv(3);
        chk(drive_en, 1'b0, "R1 drive in reset");
        chk(vco_bypass, 1'b0, "R1 bypass in reset");
        rst_n = 1'b1;
        vcc_below_stop = 1'b0;
        adv(4);
        chk(drive_en, 1'b0, "R2 no start without rise");
        vcc_above_start = 1'b1;
        adv(1);
        chk(drive_en, 1'b1, "R2 start one cycle after rise");

        // R3: undervoltage while running.
        vcc_below_stop = 1'b1;
        adv(1);
        chk(drive_en, 1'b0, "R3 drive off on undervoltage");
        vcc_below_stop = 1'b0;
        adv(3);
        chk(drive_en, 1'b0, "R2 held start level does not restart");
        supply_restart();
        chk(drive_en, 1'b1, "R2 restart after new rise");

        // R5 sweep: faults shorter than the window never stop drive.
        for (int len = 1; len < W; len += 5) begin
            int bad = 0;
            fb_low = 1'b1;
            adv(1);
            chk(vco_bypass, 1'b1, "R4 flag sets after one cycle");
            if (len > 1) adv(len - 1);
            fb_low = 1'b0;
            fb_recovered = 1'b1;
            for (int k = 0; k < W + 8; k++) begin
                adv(1);
                if (drive_en !== 1'b1) bad++;
            end
            chk(bad == 0, 1'b1, "R5 short fault keeps drive");
            chk(vco_bypass, 1'b0, "R4 flag clears on recovery");
            fb_recovered = 1'b0;
            adv(1);
        end

        // R6/R7: persistent fault, released to the hysteresis band.
        t = 0;
        fb_low = 1'b1;
        adv_to(2);
        fb_low = 1'b0;
        adv_to(7);
        chk(vco_bypass, 1'b1, "R4 flag holds in hysteresis band");
        adv_to(W + 1);
        chk(drive_en, 1'b1, "R6 drive still on before window end");
        adv_to(W + 2);
        chk(drive_en, 1'b0, "R6 drive off at W+2");
        adv_to(W + 2 + 8 * W - 1);
        chk(drive_en, 1'b0, "R7 still off before off period ends");
        adv_to(W + 2 + 8 * W);
        chk(drive_en, 1'b1, "R7 burst restarts after 8W");
        chk(vco_bypass, 1'b1, "R4 bypass during burst");
        adv_to(1 + 10 * W);
        chk(drive_en, 1'b1, "R7 burst lasts W");
        adv_to(2 + 10 * W);
        chk(drive_en, 1'b0, "R7 burst ends after W");

        // R10: supply activity during the off period is ignored.
        adv_to(2 + 10 * W + 10);
        vcc_below_stop = 1'b1;
        vcc_above_start = 1'b0;
        adv(5);
        vcc_below_stop = 1'b0;
        adv(3);
        vcc_above_start = 1'b1;
        adv(1);
        chk(drive_en, 1'b0, "R10 supply rise ignored in off period");
        adv_to(1 + 18 * W);
        chk(drive_en, 1'b0, "R10 off period length unchanged");
        adv_to(2 + 18 * W);
        chk(drive_en, 1'b1, "R10 off period ends at 8W");

        // R8: recovery during the off period waits for a supply rise.
        adv_to(2 + 19 * W + 5);
        chk(drive_en, 1'b0, "R8 in off period");
        fb_recovered = 1'b1;
        adv(2);
        fb_recovered = 1'b0;
        t0 = t;
        adv_to(t0 + 9 * W);
        chk(drive_en, 1'b0, "R8 no restart without supply rise");
        chk(vco_bypass, 1'b0, "R8 flag cleared");
        supply_restart();
        chk(drive_en, 1'b1, "R8 restart on supply rise");

        // R9: over-voltage latch.
        ovp_trip = 1'b1;
        adv(1);
        chk(drive_en, 1'b0, "R9 drive off on ovp");
        ovp_trip = 1'b0;
        adv(3);
        chk(drive_en, 1'b0, "R9 stays off after ovp release");
        vcc_above_start = 1'b0;
        adv(1);
        vcc_above_start = 1'b1;
        adv(2);
        chk(drive_en, 1'b0, "R9 supply rise does not clear latch");
        vcc_below_stop = 1'b1;
        adv(1);
        vcc_below_stop = 1'b0;
        adv(1);
        chk(drive_en, 1'b0, "R9 waits for rise after unlatch");
        supply_restart();
        chk(drive_en, 1'b1, "R9 restart after undervoltage");

        // R11: ovp seen while waiting for supply.
        vcc_below_stop = 1'b1;
        vcc_above_start = 1'b0;
        adv(1);
        vcc_below_stop = 1'b0;
        adv(1);
        ovp_trip = 1'b1;
        adv(1);
        ovp_trip = 1'b0;
        vcc_above_start = 1'b1;
        adv(2);
        chk(drive_en, 1'b0, "R11 ovp while waiting latches");
        vcc_below_stop = 1'b1;
        adv(1);
        supply_restart();
        chk(drive_en, 1'b1, "R11 restart after unlatch");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule